// File: doc/BRIEF.md
# Sequenced Eight-Bit Calculator

This block is a small byte-serial calculator with its own control sequencer. A synchronous restart returns it to idle; a start pulse then opens a transaction. The client presents bytes one at a time on a shared input with a valid qualifier. The first byte carries the operation code in its low four bits. The second byte is operand A. A third byte, operand B, follows only when the operation needs two operands.

Once the operands are in, the sequencer spends one cycle executing. It then writes the result and a carry flag into output registers and pulses a done strobe. Several operations are supported. Add and subtract share one carry-lookahead adder. AND, OR and NOT work bitwise. Single-position rotates and logical shifts go through one shifter. An opcode outside the defined set ends the transaction at once with a one-cycle error strobe.

Top module: `seq_calc8`

## Requirements
- R1: While the asynchronous reset is asserted, and after it is released, result, carry, done and err are all 0 until an operation completes.
- R2: A transaction begins only on a start pulse in idle. Bytes offered while idle, and start pulses during a transaction, have no effect on the outputs. Bytes are taken in the order opcode, operand A, then operand B, and only the low four bits of the opcode byte are decoded.
- R3: Opcode 0000 (add) yields result = (A + B) mod 256, with carry equal to bit 8 of the unsigned sum.
- R4: Opcode 0001 (subtract) yields result = (A + ~B + 1) mod 256, with carry 1 exactly when A >= B as unsigned values.
- R5: Opcode 0100 yields A AND B and opcode 0101 yields A OR B, each bitwise with carry 0.
- R6: Opcode 0110 yields the bitwise inverse of A with carry 0. It takes no B byte: execution follows the A byte directly, and a byte offered in the execute cycle is ignored.
- R7: Opcode 1000 rotates A left by one position (bit 7 moves to bit 0). Opcode 1001 rotates A right by one position (bit 0 moves to bit 7). Carry is 0 for both.
- R8: Opcode 1010 shifts A left by one and opcode 1011 shifts A right by one. Each inserts a zero at the vacated end, and carry is 0.
- R9: Any other opcode (0010, 0011, 0111, 1100 to 1111) raises err for exactly one cycle after the opcode is taken. The result and carry are left unchanged, and the block returns to idle.
- R10: done is high for exactly one cycle, and that is the cycle in which the new result and carry first appear. The result never changes otherwise, except when restart clears it.
- R11: A synchronous restart, seen in any state, clears result, carry, done, err and all operand registers, and returns the sequencer to idle. It takes priority over a result write in the same cycle.
- R12: While the sequencer waits for a byte, cycles with in_valid low leave it waiting without loss of the bytes already taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| restart | input | 1 | Synchronous clear and return to idle |
| start | input | 1 | Opens a transaction when idle |
| in_valid | input | 1 | Qualifies in_byte for one clock edge |
| in_byte | input | 8 | Shared opcode/operand byte input |
| result | output | 8 | Registered result |
| carry | output | 1 | Registered carry flag |
| done | output | 1 | One-cycle strobe on result write |
| err | output | 1 | One-cycle strobe on unused opcode |

## Verification
Restart and the result write can land in the same cycle. This happens when restart arrives in the execute cycle that follows the final operand. The bench provokes it by raising restart right after the last byte is taken. It then judges that result and carry read zero and that done stays low. A second collision is a byte offered in the execute cycle of a one-operand operation. That byte must not be taken as operand B, and the result must be computed from A alone.

// File: rtl/calc_pkg.sv
package calc_pkg;

  localparam int unsigned OPC_W = 4;

  typedef logic [OPC_W-1:0] opc_t;

  localparam opc_t OPC_ADD = 4'b0000;
  localparam opc_t OPC_SUB = 4'b0001;
  localparam opc_t OPC_AND = 4'b0100;
  localparam opc_t OPC_OR  = 4'b0101;
  localparam opc_t OPC_NOT = 4'b0110;
  localparam opc_t OPC_ROL = 4'b1000;
  localparam opc_t OPC_ROR = 4'b1001;
  localparam opc_t OPC_SHL = 4'b1010;
  localparam opc_t OPC_SHR = 4'b1011;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_OPA,
    ST_OPB,
    ST_EXEC
  } calc_state_e;

  function automatic logic opc_known(input opc_t op);
    case (op)
      OPC_ADD, OPC_SUB, OPC_AND, OPC_OR, OPC_NOT,
      OPC_ROL, OPC_ROR, OPC_SHL, OPC_SHR: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic opc_binary(input opc_t op);
    case (op)
      OPC_ADD, OPC_SUB, OPC_AND, OPC_OR: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/calc_rst_sync.sv
module calc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/calc_ctrl.sv
module calc_ctrl
  import calc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic start,
  input  logic in_valid,
  input  opc_t in_opc,
  output opc_t opc_q,
  output logic ld_a,
  output logic ld_b,
  output logic wr_res,
  output logic done_q,
  output logic err_q
);
  calc_state_e st_q, st_nxt;
  logic        ld_opc;
  logic        abort;

  // next-state and load decode
  always_comb begin
    st_nxt = st_q;
    ld_opc = 1'b0;
    ld_a   = 1'b0;
    ld_b   = 1'b0;
    wr_res = 1'b0;
    abort  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) st_nxt = ST_OPC;
      end
      ST_OPC: begin
        if (in_valid) begin
          if (opc_known(in_opc)) begin
            ld_opc = 1'b1;
            st_nxt = ST_OPA;
          end else begin
            abort  = 1'b1;
            st_nxt = ST_IDLE;
          end
        end
      end
      ST_OPA: begin
        if (in_valid) begin
          ld_a   = 1'b1;
          st_nxt = opc_binary(opc_q) ? ST_OPB : ST_EXEC;
        end
      end
      ST_OPB: begin
        if (in_valid) begin
          ld_b   = 1'b1;
          st_nxt = ST_EXEC;
        end
      end
      ST_EXEC: begin
        wr_res = 1'b1;
        st_nxt = ST_IDLE;
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  // state and strobe registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      opc_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (restart) begin
      st_q   <= ST_IDLE;
      opc_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_nxt;
      done_q <= wr_res;
      err_q  <= abort;
      if (ld_opc) opc_q <= in_opc;
    end
  end

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_err_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> !err_q);

  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_q, err_q}));

  assert_restart_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (st_q == ST_IDLE && !done_q && !err_q));

  assert_unary_skip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OPA && in_valid && !restart && !opc_binary(opc_q)) |=> (st_q == ST_EXEC));

  assert_idle_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !start && !restart) |=> (st_q == ST_IDLE));
endmodule

// File: rtl/calc_adder.sv
module calc_adder #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W-1:0] b_eff;
  logic [W-1:0] gen;
  logic [W-1:0] prop;
  logic [W:0]   carry;

  assign b_eff    = sub ? ~b : b;
  assign gen      = a & b_eff;
  assign prop     = a ^ b_eff;
  assign carry[0] = sub;

  // generate/propagate carry network
  for (genvar i = 0; i < W; i++) begin : g_carry
    assign carry[i+1] = gen[i] | (prop[i] & carry[i]);
  end

  assign sum  = prop ^ carry[W-1:0];
  assign cout = carry[W];
endmodule

// File: rtl/calc_shifter.sv
module calc_shifter #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] val,
  input  logic         to_right,
  input  logic         rotate,
  output logic [W-1:0] out
);
  logic fill;

  always_comb begin
    if (!rotate)       fill = 1'b0;
    else if (to_right) fill = val[0];
    else               fill = val[W-1];
  end

  assign out = to_right ? {fill, val[W-1:1]} : {val[W-2:0], fill};
endmodule

// File: rtl/seq_calc8.sv
module seq_calc8
  import calc_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              start,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_byte,
  output logic [DATA_W-1:0] result,
  output logic              carry,
  output logic              done,
  output logic              err
);
  logic              rst_s;
  opc_t              opc_q;
  logic              ld_a, ld_b, wr_res;
  logic [DATA_W-1:0] a_q, b_q, res_q;
  logic              c_q;
  logic [DATA_W-1:0] sum, sh_out, res_nxt;
  logic              cout, c_nxt, is_sub;

  calc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_s)
  );

  calc_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_s),
    .restart  (restart),
    .start    (start),
    .in_valid (in_valid),
    .in_opc   (in_byte[OPC_W-1:0]),
    .opc_q    (opc_q),
    .ld_a     (ld_a),
    .ld_b     (ld_b),
    .wr_res   (wr_res),
    .done_q   (done),
    .err_q    (err)
  );

  assign is_sub = (opc_q == OPC_SUB);

  calc_adder #(.W(DATA_W)) u_add (
    .a    (a_q),
    .b    (b_q),
    .sub  (is_sub),
    .sum  (sum),
    .cout (cout)
  );

  calc_shifter #(.W(DATA_W)) u_shf (
    .val      (a_q),
    .to_right (opc_q[0]),
    .rotate   (!opc_q[1]),
    .out      (sh_out)
  );

  // result select
  always_comb begin
    res_nxt = '0;
    c_nxt   = 1'b0;
    case (opc_q)
      OPC_ADD, OPC_SUB: begin
        res_nxt = sum;
        c_nxt   = cout;
      end
      OPC_AND: res_nxt = a_q & b_q;
      OPC_OR:  res_nxt = a_q | b_q;
      OPC_NOT: res_nxt = ~a_q;
      OPC_ROL, OPC_ROR, OPC_SHL, OPC_SHR: res_nxt = sh_out;
      default: res_nxt = '0;
    endcase
  end

  // operand and result registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      a_q   <= '0;
      b_q   <= '0;
      res_q <= '0;
      c_q   <= 1'b0;
    end else if (restart) begin
      a_q   <= '0;
      b_q   <= '0;
      res_q <= '0;
      c_q   <= 1'b0;
    end else begin
      if (ld_a) a_q <= in_byte;
      if (ld_b) b_q <= in_byte;
      if (wr_res) begin
        res_q <= res_nxt;
        c_q   <= c_nxt;
      end
    end
  end

  assign result = res_q;
  assign carry  = c_q;

  assert_err_keeps_result_R9: assert property (@(posedge clk) disable iff (!rst_s)
    err |-> ($stable(res_q) && $stable(c_q)));

  assert_result_quiet_R10: assert property (@(posedge clk) disable iff (!rst_s)
    (!done && !$past(restart)) |-> $stable(res_q));

  assert_restart_clears_R11: assert property (@(posedge clk) disable iff (!rst_s)
    restart |=> (res_q == '0 && !c_q));
endmodule

// File: tb/seq_calc8_tb.sv
module seq_calc8_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       restart;
  logic       start;
  logic       in_valid;
  logic [7:0] in_byte;
  logic [7:0] result;
  logic       carry;
  logic       done;
  logic       err;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit ended  = 1'b0;

  always #5 clk = ~clk;

  seq_calc8 #(.DATA_W(8)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .start    (start),
    .in_valid (in_valid),
    .in_byte  (in_byte),
    .result   (result),
    .carry    (carry),
    .done     (done),
    .err      (err)
  );

  // opcode, A, B
  localparam int NV = 20;
  localparam logic [19:0] VECS [NV] = '{
    {4'h0, 8'h12, 8'h34},
    {4'h0, 8'hFF, 8'h01},
    {4'h0, 8'h7F, 8'h01},
    {4'h0, 8'hC8, 8'hC8},
    {4'h1, 8'h00, 8'h01},
    {4'h1, 8'h05, 8'h05},
    {4'h1, 8'h80, 8'h7F},
    {4'h1, 8'h10, 8'h30},
    {4'h4, 8'hF0, 8'h3C},
    {4'h4, 8'hAA, 8'h55},
    {4'h5, 8'hF0, 8'h0F},
    {4'h5, 8'h81, 8'h18},
    {4'h6, 8'h00, 8'h77},
    {4'h6, 8'hA5, 8'h00},
    {4'h8, 8'h80, 8'h00},
    {4'h8, 8'h4B, 8'h00},
    {4'h9, 8'h01, 8'h00},
    {4'h9, 8'hD2, 8'h00},
    {4'hA, 8'h81, 8'h00},
    {4'hB, 8'h81, 8'h00}
  };

  function automatic logic [8:0] model(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b);
    logic [8:0] r;
    case (op)
      4'h0: r = {1'b0, a} + {1'b0, b};
      4'h1: r = {(a >= b), a - b};
      4'h4: r = {1'b0, a & b};
      4'h5: r = {1'b0, a | b};
      4'h6: r = {1'b0, ~a};
      4'h8: r = {1'b0, a[6:0], a[7]};
      4'h9: r = {1'b0, a[0], a[7:1]};
      4'hA: r = {1'b0, a[6:0], 1'b0};
      4'hB: r = {1'b0, 1'b0, a[7:1]};
      default: r = 9'h0;
    endcase
    return r;
  endfunction

  function automatic bit two_ops(input logic [3:0] op);
    return (op == 4'h0) || (op == 4'h1) || (op == 4'h4) || (op == 4'h5);
  endfunction

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'h0: return "R3";
      4'h1: return "R4";
      4'h4, 4'h5: return "R5";
      4'h6: return "R6";
      4'h8, 4'h9: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] v, input int gap);
    for (int g = 0; g < gap; g++) begin
      in_valid = 1'b0;
      @(negedge clk);
    end
    in_valid = 1'b1;
    in_byte  = v;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // leaves the bench at the negedge inside the execute cycle
  task automatic feed_op(input logic [7:0] opb, input logic [7:0] a, input logic [7:0] b, input int gap);
    pulse_start();
    send_byte(opb, gap);
    send_byte(a, gap);
    if (two_ops(opb[3:0])) send_byte(b, gap);
    in_valid = 1'b0;
  endtask

  task automatic run_and_check(input logic [7:0] opb, input logic [7:0] a, input logic [7:0] b,
                               input int gap, input string req);
    logic [8:0] e;
    e = model(opb[3:0], a, b);
    feed_op(opb, a, b, gap);
    @(negedge clk);
    chk(req, {carry, result}, e);
    chk("R10", {8'h0, done}, 9'h1);
    @(negedge clk);
    chk("R10", {8'h0, done}, 9'h0);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000 && !ended) begin
      ended = 1'b1;
      n_fail++;
      $display("FAIL watchdog R2 actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    restart  = 1'b0;
    start    = 1'b0;
    in_valid = 1'b0;
    in_byte  = 8'h00;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk("R1", {carry, result}, 9'h0);
    chk("R1", {7'h0, done, err}, 9'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", {carry, result}, 9'h0);
    chk("R1", {7'h0, done, err}, 9'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [3:0] op;
      op = VECS[i][19:16];
      run_and_check({4'h0, op}, VECS[i][15:8], VECS[i][7:0], 0, req_of(op));
    end

    // R12: stalls between bytes
    run_and_check(8'h01, 8'h9C, 8'h2D, 2, "R12");
    run_and_check(8'h0A, 8'h55, 8'h00, 3, "R12");

    // R2: only low opcode bits decode (0xA4 -> AND)
    run_and_check(8'hA4, 8'h6E, 8'h3B, 0, "R2");

    // R2: bytes while idle are ignored
    run_and_check(8'h00, 8'h10, 8'h20, 0, "R3");
    for (int k = 0; k < 4; k++) begin
      in_valid = 1'b1;
      in_byte  = 8'h01 + 8'(k);
      @(negedge clk);
      chk("R2", {8'h0, done}, 9'h0);
    end
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2", {carry, result}, 9'h030);

    // R2: start during a transaction has no effect
    pulse_start();
    send_byte(8'h00, 0);
    start = 1'b1;
    send_byte(8'h03, 0);
    send_byte(8'h04, 0);
    start = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    chk("R2", {carry, result}, 9'h007);
    chk("R2", {8'h0, done}, 9'h1);
    @(negedge clk);

    // R6: byte during execute of a one-operand op is ignored
    pulse_start();
    send_byte(8'h06, 0);
    send_byte(8'h3C, 0);
    in_byte = 8'h99;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R6", {carry, result}, 9'h0C3);
    chk("R6", {8'h0, done}, 9'h1);
    @(negedge clk);
    run_and_check(8'h05, 8'h01, 8'h02, 0, "R6");

    // R9: unused opcodes
    for (int u = 0; u < 7; u++) begin
      logic [3:0] bad;
      case (u)
        0: bad = 4'h2;
        1: bad = 4'h3;
        2: bad = 4'h7;
        3: bad = 4'hC;
        4: bad = 4'hD;
        5: bad = 4'hE;
        default: bad = 4'hF;
      endcase
      pulse_start();
      send_byte({4'h0, bad}, 0);
      chk("R9", {8'h0, err}, 9'h1);
      send_byte(8'hEE, 0);
      chk("R9", {8'h0, err}, 9'h0);
      send_byte(8'hEE, 0);
      in_valid = 1'b0;
      @(negedge clk);
      chk("R9", {8'h0, done}, 9'h0);
      chk("R9", {carry, result}, 9'h003);
    end
    run_and_check(8'h09, 8'h02, 8'h00, 0, "R9");

    // R11: restart collides with the result write
    run_and_check(8'h00, 8'hF0, 8'h20, 0, "R3");
    feed_op(8'h00, 8'h11, 8'h22, 0);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    chk("R11", {carry, result}, 9'h0);
    chk("R11", {8'h0, done}, 9'h0);

    // R11: restart mid-sequence, then bytes without start are ignored
    run_and_check(8'h05, 8'h40, 8'h04, 0, "R5");
    pulse_start();
    send_byte(8'h00, 0);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    send_byte(8'h05, 0);
    send_byte(8'h06, 0);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11", {carry, result}, 9'h0);
    chk("R11", {8'h0, done}, 9'h0);
    run_and_check(8'h01, 8'h03, 8'h01, 0, "R11");

    ended = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule